// File: doc/BRIEF.md
# Thermal Limit Latch with Multi-Function Pin

The block watches the temperature of two remote sensing channels and raises a latched thermal event when the selected channel runs hot. Temperatures and limits are signed numbers in quarter-degree steps. The event trips once the reading is at least one step above the channel's limit. It then stays set until two things are true: the reading has fallen below the limit, and the associated status bit has been cleared by a read. While the event is set, the block asks for full fan speed. A configuration bit can turn that request off.

A single pad is shared between four functions, chosen by a two-bit field:

| Code | Function |
|------|----------|
| 00 | Thermal event output |
| 01 | Tachometer input |
| 10 | General-purpose I/O |
| 11 | Alert output |

In thermal mode the pad drives only when a separate enable is set. The event and alert outputs are active low. In tachometer mode the pad is an input only. Each channel's limit is held in a register inside the block. After reset the limits are 100 °C for remote channel 1 and 136 °C for remote channel 2. A write port replaces either limit.

Top module: `therm_latch_pinmux`

## Requirements
- R1: After reset, therm_o and stat_o are 0. The channel 1 limit is 400 (100 °C) and the channel 2 limit is 544 (136 °C), in units of 0.25 °C.
- R2: If the selected temperature exceeds its limit by at least one LSB at a rising clock edge, therm_o and stat_o are 1 after that edge. A temperature equal to the limit does not trip.
- R3: Once set, therm_o stays 1 while the selected temperature is not below its limit, or while stat_o is 1.
- R4: A stat_rd_i pulse clears stat_o at the next edge only if the selected temperature is below its limit. Otherwise the pulse has no effect.
- R5: therm_o clears at the first edge where the selected temperature is below its limit and stat_o is already 0.
- R6: ch_sel_i=0 compares channel 1 and ch_sel_i=1 compares channel 2. The unselected channel's temperature has no effect.
- R7: fan_full_o equals therm_o while fan_ovr_dis_i=0, and is 0 while fan_ovr_dis_i=1.
- R8: lim_wr_i loads lim_data_i into the limit of channel lim_ch_i (0 = channel 1, 1 = channel 2). The new limit applies from the next edge.
- R9: With pin_func_i=00, pin_oe_o equals therm_en_i. When pin_oe_o is 1, pin_o is the inverse of therm_o.
- R10: With pin_func_i=11, pin_oe_o is 1 and pin_o is the inverse of alert_i.
- R11: With pin_func_i=10, pin_o equals gpio_out_i, pin_oe_o equals gpio_oe_i, and gpio_in_o equals pin_i.
- R12: With pin_func_i=01, pin_oe_o is 0 and tach_o equals pin_i. In every other mode, tach_o and gpio_in_o (outside mode 10) are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_r1_i | input | 12 | Channel 1 temperature, signed, 0.25 °C per LSB |
| temp_r2_i | input | 12 | Channel 2 temperature, signed, 0.25 °C per LSB |
| lim_wr_i | input | 1 | Limit write strobe |
| lim_ch_i | input | 1 | Limit write target (0 = channel 1, 1 = channel 2) |
| lim_data_i | input | 12 | Limit write value, signed |
| ch_sel_i | input | 1 | Channel that drives the latch |
| fan_ovr_dis_i | input | 1 | Disables the full-speed fan request |
| therm_en_i | input | 1 | Enables the pad in thermal mode |
| pin_func_i | input | 2 | Pad function select |
| stat_rd_i | input | 1 | Status read-clear strobe |
| alert_i | input | 1 | Alert request, active high |
| gpio_out_i | input | 1 | GPIO output level |
| gpio_oe_i | input | 1 | GPIO output enable |
| pin_i | input | 1 | Pad input level |
| therm_o | output | 1 | Latched thermal event |
| stat_o | output | 1 | Sticky trip status |
| fan_full_o | output | 1 | Full fan speed request |
| pin_o | output | 1 | Pad output level |
| pin_oe_o | output | 1 | Pad output enable |
| tach_o | output | 1 | Tachometer input from the pad |
| gpio_in_o | output | 1 | GPIO input from the pad |

## Verification
A wrong latch or status state shows up on therm_o, stat_o and fan_full_o one edge after the stimulus that should have set or released it. In thermal mode the same fault also appears inverted on pin_o. A bad limit register or a wrong compare boundary shows up as a trip that is off by one LSB, or as a trip on the wrong channel. The directed sequence steps exactly across those boundaries. Pad multiplexing errors are combinational, so they are visible on pin_o, pin_oe_o, tach_o and gpio_in_o in the same cycle the mode changes.

// File: rtl/therm_pkg.sv
package therm_pkg;
  localparam int unsigned TEMP_W = 12;
  localparam int signed LIM1_DEF = 400;  // 100 C in 0.25 C steps
  localparam int signed LIM2_DEF = 544;  // 136 C in 0.25 C steps

  typedef enum logic [1:0] {
    PIN_THERM = 2'b00,
    PIN_TACH  = 2'b01,
    PIN_GPIO  = 2'b10,
    PIN_ALERT = 2'b11
  } pin_func_e;
endpackage

// File: rtl/therm_cmp.sv
module therm_cmp
  import therm_pkg::*;
#(
  parameter int unsigned TW = TEMP_W,
  parameter int signed L1_DEF = LIM1_DEF,
  parameter int signed L2_DEF = LIM2_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [TW-1:0] temp_r1_i,
  input  logic signed [TW-1:0] temp_r2_i,
  input  logic                 lim_wr_i,
  input  logic                 lim_ch_i,
  input  logic signed [TW-1:0] lim_data_i,
  input  logic                 ch_sel_i,
  output logic                 hot_o,
  output logic                 cool_o
);
  localparam int NCH = 2;
  localparam logic signed [TW-1:0] DEF [NCH] = '{L1_DEF[TW-1:0], L2_DEF[TW-1:0]};

  logic signed [TW-1:0] lim_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_lim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lim_q[c] <= DEF[c];
      else if (lim_wr_i && (lim_ch_i == c[0])) lim_q[c] <= lim_data_i;
    end
  end

  logic signed [TW-1:0] t_sel, l_sel;
  assign t_sel = ch_sel_i ? temp_r2_i : temp_r1_i;
  assign l_sel = ch_sel_i ? lim_q[1] : lim_q[0];

  // trip point is limit + 1 LSB; strictly below the limit releases
  assign hot_o  = t_sel > l_sel;
  assign cool_o = t_sel < l_sel;
endmodule

// File: rtl/therm_latch.sv
module therm_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic cool_i,
  input  logic rd_i,
  output logic latch_o,
  output logic stat_o
);
  logic latch_q, stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      if (hot_i) stat_q <= 1'b1;
      else if (rd_i && cool_i) stat_q <= 1'b0;

      if (hot_i) latch_q <= 1'b1;
      else if (cool_i && !stat_q) latch_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign stat_o  = stat_q;

  // R2
  trip_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_i |=> (latch_q && stat_q));
  // R5
  release_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_q) |-> $past(cool_i && !stat_q));
  // R4
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_q) |-> $past(rd_i && cool_i));
  // R3
  stat_implies_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q |-> latch_q);
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import therm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] func_i,
  input  logic       therm_en_i,
  input  logic       event_i,
  input  logic       alert_i,
  input  logic       gpio_out_i,
  input  logic       gpio_oe_i,
  input  logic       pin_i,
  output logic       pin_o,
  output logic       pin_oe_o,
  output logic       tach_o,
  output logic       gpio_in_o
);
  pin_func_e fn;
  assign fn = pin_func_e'(func_i);

  always_comb begin
    pin_o     = 1'b1;
    pin_oe_o  = 1'b0;
    tach_o    = 1'b0;
    gpio_in_o = 1'b0;
    unique case (fn)
      PIN_THERM: begin
        pin_oe_o = therm_en_i;
        pin_o    = therm_en_i ? ~event_i : 1'b1;
      end
      PIN_TACH:  tach_o = pin_i;
      PIN_GPIO: begin
        pin_o     = gpio_out_i;
        pin_oe_o  = gpio_oe_i;
        gpio_in_o = pin_i;
      end
      PIN_ALERT: begin
        pin_oe_o = 1'b1;
        pin_o    = ~alert_i;
      end
      default: ;
    endcase
  end

  // R12
  tach_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn == PIN_TACH) |-> !pin_oe_o);
  // R9
  therm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn == PIN_THERM && !therm_en_i) |-> (!pin_oe_o && pin_o));
endmodule

// File: rtl/therm_latch_pinmux.sv
module therm_latch_pinmux
  import therm_pkg::*;
#(
  parameter int unsigned TW = TEMP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [TW-1:0] temp_r1_i,
  input  logic signed [TW-1:0] temp_r2_i,
  input  logic                 lim_wr_i,
  input  logic                 lim_ch_i,
  input  logic signed [TW-1:0] lim_data_i,
  input  logic                 ch_sel_i,
  input  logic                 fan_ovr_dis_i,
  input  logic                 therm_en_i,
  input  logic [1:0]           pin_func_i,
  input  logic                 stat_rd_i,
  input  logic                 alert_i,
  input  logic                 gpio_out_i,
  input  logic                 gpio_oe_i,
  input  logic                 pin_i,
  output logic                 therm_o,
  output logic                 stat_o,
  output logic                 fan_full_o,
  output logic                 pin_o,
  output logic                 pin_oe_o,
  output logic                 tach_o,
  output logic                 gpio_in_o
);
  logic hot, cool;

  therm_cmp #(.TW(TW)) i_cmp (
    .clk_i, .rst_ni, .temp_r1_i, .temp_r2_i, .lim_wr_i, .lim_ch_i,
    .lim_data_i, .ch_sel_i, .hot_o(hot), .cool_o(cool)
  );

  therm_latch i_latch (
    .clk_i, .rst_ni, .hot_i(hot), .cool_i(cool), .rd_i(stat_rd_i),
    .latch_o(therm_o), .stat_o(stat_o)
  );

  assign fan_full_o = therm_o && !fan_ovr_dis_i;

  pin_mux i_mux (
    .clk_i, .rst_ni, .func_i(pin_func_i), .therm_en_i, .event_i(therm_o),
    .alert_i, .gpio_out_i, .gpio_oe_i, .pin_i, .pin_o, .pin_oe_o,
    .tach_o, .gpio_in_o
  );

  // R7
  fan_needs_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fan_full_o |-> (therm_o && !fan_ovr_dis_i));
endmodule

// File: tb/test_therm_latch_pinmux.sv
module test_therm_latch_pinmux;
  localparam time CLK_PERIOD = 10ns;
  localparam int TW = 12;

  logic clk = 0, rst_ni = 0;
  logic signed [TW-1:0] temp_r1 = 0, temp_r2 = 0, lim_data = 0;
  logic lim_wr = 0, lim_ch = 0, ch_sel = 0, fan_dis = 0, therm_en = 0;
  logic [1:0] pin_func = 2'b01;
  logic stat_rd = 0, alert = 0, gpio_out = 0, gpio_oe = 0, pin_in = 0;
  logic therm, stat, fan_full, pin_out, pin_oe, tach, gpio_in;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  therm_latch_pinmux i_therm_latch_pinmux (
    .clk_i(clk), .rst_ni, .temp_r1_i(temp_r1), .temp_r2_i(temp_r2),
    .lim_wr_i(lim_wr), .lim_ch_i(lim_ch), .lim_data_i(lim_data),
    .ch_sel_i(ch_sel), .fan_ovr_dis_i(fan_dis), .therm_en_i(therm_en),
    .pin_func_i(pin_func), .stat_rd_i(stat_rd), .alert_i(alert),
    .gpio_out_i(gpio_out), .gpio_oe_i(gpio_oe), .pin_i(pin_in),
    .therm_o(therm), .stat_o(stat), .fan_full_o(fan_full), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .tach_o(tach), .gpio_in_o(gpio_in)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_pulse();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 therm reset", therm, 0);
    chk("R1 stat reset", stat, 0);
    chk("R7 fan reset", fan_full, 0);
  endtask

  task automatic t_trip_release();
    ch_sel = 0; temp_r1 = 400; tick();
    chk("R1/R2 at default limit no trip", therm, 0);
    temp_r1 = 401; tick();
    chk("R2 trip therm", therm, 1);
    chk("R2 trip stat", stat, 1);
    chk("R7 fan full", fan_full, 1);
    fan_dis = 1; #1;
    chk("R7 fan disabled", fan_full, 0);
    fan_dis = 0;
    temp_r1 = 400; rd_pulse();
    chk("R4 read ignored at limit", stat, 1);
    chk("R3 hold at limit", therm, 1);
    temp_r1 = 399; tick();
    chk("R3 hold while stat set", therm, 1);
    rd_pulse();
    chk("R4 read clears when cool", stat, 0);
    chk("R5 still set same edge", therm, 1);
    tick();
    chk("R5 released", therm, 0);
  endtask

  task automatic t_channel();
    ch_sel = 1; temp_r1 = 900; temp_r2 = 544; tick();
    chk("R6 channel 1 ignored", therm, 0);
    chk("R1 ch2 default no trip at 544", stat, 0);
    temp_r2 = 545; tick();
    chk("R6 channel 2 trip", therm, 1);
    temp_r2 = 0; rd_pulse(); tick();
    chk("R6 channel 2 release", therm, 0);
    temp_r1 = 0;
  endtask

  task automatic t_limit_write();
    lim_wr = 1; lim_ch = 0; lim_data = 200; tick(); lim_wr = 0;
    ch_sel = 0; temp_r1 = 200; tick();
    chk("R8 new limit equal no trip", therm, 0);
    temp_r1 = 201; tick();
    chk("R8 new limit trip", therm, 1);
  endtask

  task automatic t_pin_therm();
    pin_func = 2'b00; therm_en = 0; #1;
    chk("R9 disabled oe", pin_oe, 0);
    therm_en = 1; #1;
    chk("R9 enabled oe", pin_oe, 1);
    chk("R9 active low event", pin_out, 0);
    temp_r1 = 0; rd_pulse(); tick();
    chk("R9 idle high", pin_out, 1);
  endtask

  task automatic t_pin_other();
    pin_func = 2'b11; alert = 1; #1;
    chk("R10 alert oe", pin_oe, 1);
    chk("R10 alert low", pin_out, 0);
    alert = 0; #1;
    chk("R10 alert idle", pin_out, 1);
    pin_func = 2'b10; gpio_oe = 1; gpio_out = 0; pin_in = 1; #1;
    chk("R11 gpio oe", pin_oe, 1);
    chk("R11 gpio out", pin_out, 0);
    chk("R11 gpio in", gpio_in, 1);
    chk("R12 tach zero in gpio", tach, 0);
    gpio_oe = 0; #1;
    chk("R11 gpio oe off", pin_oe, 0);
    pin_func = 2'b01; pin_in = 1; #1;
    chk("R12 tach no oe", pin_oe, 0);
    chk("R12 tach high", tach, 1);
    chk("R12 gpio_in zero", gpio_in, 0);
    pin_in = 0; #1;
    chk("R12 tach low", tach, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1; tick();
    t_trip_release();
    t_channel();
    t_limit_write();
    t_pin_therm();
    t_pin_other();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule